// File: doc/BRIEF.md
# DMA Controller Register Programming Port

This block is the processor-facing register port of a DMA controller. Software reaches it only while the controller is idle, the chip select is low and the bus-grant input is low. Under those conditions a four-bit address and two active-low strobes, read and write, select and time a byte-wide access. Each channel holds a 16-bit address register and a 16-bit word count register. Both are reached one byte at a time, and a single internal byte-pointer flip-flop chooses the byte. The pointer toggles after every channel-register access, so software sends or receives the low byte first and the high byte second.

The upper half of the address map holds the control and command space. One entry writes the command register and reads status. Others write a single mask bit, all mask bits, or a channel's mode. The rest are pure commands that act on the address alone and ignore the data bus: set pointer, clear pointer, master clear and clear mask. A read of the pointer-clear address resets the mode-readback counter, and a read of the master-clear address returns the temporary register. Every access takes effect on the cycle after its strobe returns high. Read data is driven while the read strobe is low.

Top module: `dmaprog_port`

## Requirements
- R1: After reset the byte pointer is 0, all mask bits are 1, the command register is 0x00, and read data is not driven (`dout_en` low, `dout` 0).
- R2: An access attempted while `hlda` is high, `cs_n` is high or `seq_idle` is low changes no register and does not move the byte pointer.
- R3: Addresses 0x0–0x7 select channel `addr[2:1]`; `addr[0]`=0 selects the address register and 1 selects the word count register. A write loads the byte chosen by the pointer (0 = bits 7:0, 1 = bits 15:8) into both the base copy and the current copy. A read returns that byte of the current copy.
- R4: Every completed read or write of a channel register (0x0–0x7) inverts the byte pointer. Nothing else changes the pointer except R5 and R6.
- R5: A write to 0xD sets the byte pointer to 1 and a write to 0xC clears it to 0, whatever the data bus holds.
- R6: A write to 0xE (master clear) sets all mask bits and clears the command register, the status terminal-count bits, the temporary register, the byte pointer and the mode-readback counter, whatever the data bus holds.
- R7: A write to 0xF clears all mask bits. A write to 0x9 sets (`din[2]`=1) or clears (`din[2]`=0) the mask bit of channel `din[1:0]`. A write to 0xB loads all mask bits from `din[3:0]`. A read of 0xF returns `{4'b0, mask}`.
- R8: A write to 0xA stores `din[7:2]` as the mode of channel `din[1:0]`. Each read of 0xA returns `{mode[n], n}` for the counter value n and then increments n, wrapping. A read of 0xC resets n to 0 and returns 0x00.
- R9: A read of 0x8 returns `{req_in[3:0], tc[3:0]}` and then clears the terminal-count bits. A bit pulsed on `tc_set` is set, and stays set until that read.
- R10: A write to 0x8 loads the command register. A pulse on `temp_we` loads the temporary register, and a read of 0xE returns it.
- R11: `dout_en` is high only while the read strobe is low and access is permitted (R2). At all other times `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ior_n | input | 1 | Read strobe, active low |
| iow_n | input | 1 | Write strobe, active low |
| hlda | input | 1 | Bus granted to the DMA engine; blocks access when high |
| seq_idle | input | 1 | Transfer sequencer is idle |
| addr | input | 4 | Register address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Read data valid / bus drive enable |
| tc_set | input | 4 | Per-channel terminal-count set pulses from the sequencer |
| req_in | input | 4 | Per-channel request levels reported in status |
| temp_we | input | 1 | Load the temporary register |
| temp_data | input | 8 | Temporary register data |
| ff_o | output | 1 | Byte pointer state |
| cmd_o | output | 8 | Command register |
| mask_o | output | 4 | Channel mask bits |
| mode_o | output | 24 | Channel modes, 6 bits per channel, channel 0 lowest |
| base_addr_o | output | 64 | Base address copies, 16 bits per channel |
| base_cnt_o | output | 64 | Base word count copies |
| cur_addr_o | output | 64 | Current address copies |
| cur_cnt_o | output | 64 | Current word count copies |

## Verification
The properties assume that each strobe pulse stays low for at least one clock edge, that the read and write strobes never overlap, and that `tc_set` is not pulsed in the same cycle as a status-read completion. The bench drives all of its accesses through two tasks that hold each strobe low for two clock edges, change the address and data only while both strobes are high, and pulse `tc_set` only between accesses. The blocked-access cases raise `hlda` or drop `seq_idle` before the strobe falls and keep them there until after it rises, so no access is partly permitted.

// File: rtl/dmaprog_pkg.sv
package dmaprog_pkg;
   // Low three address bits inside the control half of the map (addr[3]=1).
   typedef enum logic [2:0] {
      CS_CMD_STAT = 3'd0,  // W: command register  R: status
      CS_MSK_ONE  = 3'd1,  // W: single mask bit
      CS_MODE     = 3'd2,  // W: mode write        R: mode readback
      CS_MSK_ALL  = 3'd3,  // W: all mask bits
      CS_FF_CLR   = 3'd4,  // W: clear pointer     R: clear mode counter
      CS_FF_SET   = 3'd5,  // W: set pointer
      CS_MCLR     = 3'd6,  // W: master clear      R: temporary register
      CS_MSK_CLR  = 3'd7   // W: clear mask        R: mask readback
   } cs_code_e;
endpackage

// File: rtl/dmaprog_decode.sv
module dmaprog_decode #(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          ior_n,
   input  logic          iow_n,
   input  logic          hlda,
   input  logic          seq_idle,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   output logic          rd_act,
   output logic          rd_done,
   output logic          wr_done,
   output logic [AW-1:0] a_q,
   output logic [DW-1:0] d_q
);
   logic prog_ok, wr_act, rd_q, wr_q;

   assign prog_ok = !cs_n && !hlda && seq_idle;
   assign rd_act  = prog_ok && !ior_n && iow_n;
   assign wr_act  = prog_ok && !iow_n && ior_n;

   // Side effects commit when the strobe ends, using the captured address/data.
   assign rd_done = rd_q && !rd_act;
   assign wr_done = wr_q && !wr_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b0;
         wr_q <= 1'b0;
         a_q  <= '0;
         d_q  <= '0;
      end else begin
         rd_q <= rd_act;
         wr_q <= wr_act;
         if (rd_act || wr_act) begin
            a_q <= addr;
            d_q <= din;
         end
      end
   end
endmodule

// File: rtl/dmaprog_chregs.sv
module dmaprog_chregs #(
   parameter int NUM_CH = 4,
   parameter int DW     = 8,
   localparam int RW    = 2 * DW,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [CH_W-1:0]      wr_ch,
   input  logic                 wr_sel,
   input  logic                 hi,
   input  logic [DW-1:0]        wdata,
   input  logic [CH_W-1:0]      rd_ch,
   input  logic                 rd_sel,
   output logic [DW-1:0]        rdata,
   output logic [NUM_CH*RW-1:0] base_addr_o,
   output logic [NUM_CH*RW-1:0] base_cnt_o,
   output logic [NUM_CH*RW-1:0] cur_addr_o,
   output logic [NUM_CH*RW-1:0] cur_cnt_o
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [RW-1:0] base_a, base_c, cur_a, cur_c;
      logic          hit_a, hit_c;
      assign hit_a = we && (wr_ch == CH_W'(c)) && !wr_sel;
      assign hit_c = we && (wr_ch == CH_W'(c)) &&  wr_sel;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_a <= '0;
            base_c <= '0;
            cur_a  <= '0;
            cur_c  <= '0;
         end else begin
            if (hit_a) begin
               if (hi) begin
                  base_a[RW-1:DW] <= wdata;
                  cur_a[RW-1:DW]  <= wdata;
               end else begin
                  base_a[DW-1:0]  <= wdata;
                  cur_a[DW-1:0]   <= wdata;
               end
            end
            if (hit_c) begin
               if (hi) begin
                  base_c[RW-1:DW] <= wdata;
                  cur_c[RW-1:DW]  <= wdata;
               end else begin
                  base_c[DW-1:0]  <= wdata;
                  cur_c[DW-1:0]   <= wdata;
               end
            end
         end
      end

      assign base_addr_o[c*RW +: RW] = base_a;
      assign base_cnt_o[c*RW +: RW]  = base_c;
      assign cur_addr_o[c*RW +: RW]  = cur_a;
      assign cur_cnt_o[c*RW +: RW]   = cur_c;
   end

   logic [RW-1:0] rd_word;
   always_comb begin
      rd_word = rd_sel ? cur_cnt_o[rd_ch*RW +: RW] : cur_addr_o[rd_ch*RW +: RW];
      rdata   = hi ? rd_word[RW-1:DW] : rd_word[DW-1:0];
   end
endmodule

// File: rtl/dmaprog_ctrl.sv
module dmaprog_ctrl
   import dmaprog_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int DW     = 8,
   parameter int MODE_W = 6,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_done,
   input  logic                     wr_done,
   input  logic [3:0]               a_q,
   input  logic [DW-1:0]            d_q,
   input  logic [2:0]               rd_code,
   input  logic [NUM_CH-1:0]        tc_set,
   input  logic [NUM_CH-1:0]        req_in,
   input  logic                     temp_we,
   input  logic [DW-1:0]            temp_data,
   output logic                     ff,
   output logic [DW-1:0]            cmd,
   output logic [NUM_CH-1:0]        mask,
   output logic [NUM_CH*MODE_W-1:0] mode_flat,
   output logic [NUM_CH-1:0]        tc_q,
   output logic [DW-1:0]            rdata
);
   logic [MODE_W-1:0] mode_q [NUM_CH];
   logic [CH_W-1:0]   mcnt;
   logic [DW-1:0]     temp_q;
   logic              wr_cs, rd_cs, ch_acc, mclr, stat_rd;
   cs_code_e          code;

   assign code    = cs_code_e'(a_q[2:0]);
   assign wr_cs   = wr_done && a_q[3];
   assign rd_cs   = rd_done && a_q[3];
   assign ch_acc  = (rd_done || wr_done) && !a_q[3];
   assign mclr    = wr_cs && code == CS_MCLR;
   assign stat_rd = rd_cs && code == CS_CMD_STAT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ff     <= 1'b0;
         cmd    <= '0;
         mask   <= '1;
         tc_q   <= '0;
         temp_q <= '0;
         mcnt   <= '0;
         for (int i = 0; i < NUM_CH; i++) mode_q[i] <= '0;
      end else if (mclr) begin
         ff     <= 1'b0;
         cmd    <= '0;
         mask   <= '1;
         tc_q   <= '0;
         temp_q <= '0;
         mcnt   <= '0;
      end else begin
         if (ch_acc)                          ff <= !ff;
         else if (wr_cs && code == CS_FF_CLR) ff <= 1'b0;
         else if (wr_cs && code == CS_FF_SET) ff <= 1'b1;

         if (wr_cs) begin
            case (code)
               CS_CMD_STAT: cmd <= d_q;
               CS_MSK_ONE:  mask[d_q[CH_W-1:0]] <= d_q[CH_W];
               CS_MODE:     mode_q[d_q[CH_W-1:0]] <= d_q[DW-1:CH_W];
               CS_MSK_ALL:  mask <= d_q[NUM_CH-1:0];
               CS_MSK_CLR:  mask <= '0;
               default: ;
            endcase
         end

         if (rd_cs && code == CS_MODE)        mcnt <= mcnt + 1'b1;
         else if (rd_cs && code == CS_FF_CLR) mcnt <= '0;

         tc_q <= (stat_rd ? '0 : tc_q) | tc_set;
         if (temp_we) temp_q <= temp_data;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
      assign mode_flat[c*MODE_W +: MODE_W] = mode_q[c];
   end

   always_comb begin
      case (cs_code_e'(rd_code))
         CS_CMD_STAT: rdata = {req_in, tc_q};
         CS_MODE:     rdata = {mode_q[mcnt], mcnt};
         CS_MCLR:     rdata = temp_q;
         CS_MSK_CLR:  rdata = {{(DW-NUM_CH){1'b0}}, mask};
         default:     rdata = '0;
      endcase
   end
endmodule

// File: rtl/dmaprog_port.sv
module dmaprog_port #(
   parameter int NUM_CH = 4,
   parameter int DW     = 8,
   parameter int MODE_W = 6,
   localparam int AW    = 4,
   localparam int RW    = 2 * DW
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_n,
   input  logic                     ior_n,
   input  logic                     iow_n,
   input  logic                     hlda,
   input  logic                     seq_idle,
   input  logic [AW-1:0]            addr,
   input  logic [DW-1:0]            din,
   output logic [DW-1:0]            dout,
   output logic                     dout_en,
   input  logic [NUM_CH-1:0]        tc_set,
   input  logic [NUM_CH-1:0]        req_in,
   input  logic                     temp_we,
   input  logic [DW-1:0]            temp_data,
   output logic                     ff_o,
   output logic [DW-1:0]            cmd_o,
   output logic [NUM_CH-1:0]        mask_o,
   output logic [NUM_CH*MODE_W-1:0] mode_o,
   output logic [NUM_CH*RW-1:0]     base_addr_o,
   output logic [NUM_CH*RW-1:0]     base_cnt_o,
   output logic [NUM_CH*RW-1:0]     cur_addr_o,
   output logic [NUM_CH*RW-1:0]     cur_cnt_o
);
   // Elaboration-time parameter checks.
   if (NUM_CH != 4) begin : g_bad_ch
      $error("dmaprog_port: the 4-bit map decodes exactly 4 channels");
   end
   if (2 * NUM_CH != DW) begin : g_bad_stat
      $error("dmaprog_port: status needs DW == 2*NUM_CH");
   end
   if (MODE_W + $clog2(NUM_CH) != DW) begin : g_bad_mode
      $error("dmaprog_port: mode field plus channel id must fill DW");
   end

   logic          rd_act, rd_done, wr_done;
   logic [AW-1:0] a_q;
   logic [DW-1:0] d_q, ch_rd, ctrl_rd;
   logic [NUM_CH-1:0] tc_q;

   dmaprog_decode #(.AW(AW), .DW(DW)) u_dec (
      .clk, .rst_n, .cs_n, .ior_n, .iow_n, .hlda, .seq_idle, .addr, .din,
      .rd_act, .rd_done, .wr_done, .a_q, .d_q
   );

   dmaprog_chregs #(.NUM_CH(NUM_CH), .DW(DW)) u_ch (
      .clk, .rst_n,
      .we     (wr_done && !a_q[3]),
      .wr_ch  (a_q[2:1]),
      .wr_sel (a_q[0]),
      .hi     (ff_o),
      .wdata  (d_q),
      .rd_ch  (addr[2:1]),
      .rd_sel (addr[0]),
      .rdata  (ch_rd),
      .base_addr_o, .base_cnt_o, .cur_addr_o, .cur_cnt_o
   );

   dmaprog_ctrl #(.NUM_CH(NUM_CH), .DW(DW), .MODE_W(MODE_W)) u_ctl (
      .clk, .rst_n, .rd_done, .wr_done, .a_q, .d_q,
      .rd_code   (addr[2:0]),
      .tc_set, .req_in, .temp_we, .temp_data,
      .ff        (ff_o),
      .cmd       (cmd_o),
      .mask      (mask_o),
      .mode_flat (mode_o),
      .tc_q,
      .rdata     (ctrl_rd)
   );

   assign dout_en = rd_act;
   assign dout    = rd_act ? (addr[3] ? ctrl_rd : ch_rd) : '0;
endmodule

// File: rtl/dmaprog_port_chk.sv
module dmaprog_port_chk #(
   parameter int NUM_CH = 4,
   parameter int DW     = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              hlda,
   input logic              seq_idle,
   input logic              dout_en,
   input logic              rd_done,
   input logic              wr_done,
   input logic [3:0]        a_q,
   input logic [NUM_CH-1:0] tc_set,
   input logic [NUM_CH-1:0] tc_q,
   input logic              ff_o,
   input logic [DW-1:0]     cmd_o,
   input logic [NUM_CH-1:0] mask_o
);
   // R11
   rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout_en |-> (!cs_n && !hlda && seq_idle));

   // R4
   ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ff_o) |-> $past(rd_done || wr_done));

   // R10
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_done |=> $stable(cmd_o));

   // R6
   mclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_done && a_q == 4'hE) |=> (mask_o == '1 && cmd_o == '0 && !ff_o && tc_q == '0));

   // R7
   mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_done && a_q == 4'hF) |=> (mask_o == '0));

   // R9
   stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && a_q == 4'h8 && tc_set == '0) |=> (tc_q == '0));
endmodule

bind dmaprog_port dmaprog_port_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
   .clk, .rst_n, .cs_n, .hlda, .seq_idle, .dout_en, .rd_done, .wr_done,
   .a_q, .tc_set, .tc_q, .ff_o, .cmd_o, .mask_o
);

// File: tb/dmaprog_port_test.sv
module dmaprog_port_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, ior_n = 1'b1, iow_n = 1'b1;
   logic        hlda = 1'b0, seq_idle = 1'b1;
   logic [3:0]  addr = '0;
   logic [7:0]  din = '0;
   logic [7:0]  dout;
   logic        dout_en;
   logic [3:0]  tc_set = '0, req_in = '0;
   logic        temp_we = 1'b0;
   logic [7:0]  temp_data = '0;
   logic        ff_o;
   logic [7:0]  cmd_o;
   logic [3:0]  mask_o;
   logic [23:0] mode_o;
   logic [63:0] base_addr_o, base_cnt_o, cur_addr_o, cur_cnt_o;

   int checks = 0, errors = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       chk_stb = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   dmaprog_port uut (.*);

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Monitor: compares read data against the scoreboard queue.
   always @(negedge clk) begin
      if (chk_stb) begin
         logic [7:0] e;
         string      t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk({t, " dout_en"}, {63'd0, dout_en}, 64'd1);
         chk(t, {56'd0, dout}, {56'd0, e});
      end
   end

   task automatic io_write(input logic [3:0] a, input logic [7:0] d);
      @(posedge clk); #1 addr = a; din = d; cs_n = 1'b0; iow_n = 1'b0;
      @(posedge clk); @(posedge clk); #1 iow_n = 1'b1;
      @(posedge clk); #1 cs_n = 1'b1;
      @(posedge clk); #1;
   endtask

   task automatic io_read(input logic [3:0] a, input logic [7:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(posedge clk); #1 addr = a; cs_n = 1'b0; ior_n = 1'b0;
      @(posedge clk); #1 chk_stb = 1'b1;
      @(posedge clk); #1 chk_stb = 1'b0; ior_n = 1'b1;
      @(posedge clk); #1 cs_n = 1'b1;
      @(posedge clk); #1;
   endtask

   task automatic pulse_tc(input logic [3:0] v);
      @(posedge clk); #1 tc_set = v;
      @(posedge clk); #1 tc_set = '0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ff", ff_o, 0);
      chk("R1 mask", mask_o, 4'hF);
      chk("R1 cmd", cmd_o, 0);
      chk("R1 dout_en", dout_en, 0);
      chk("R1 dout", dout, 0);

      // R3/R4 channel 1 address register, low then high byte
      io_write(4'h2, 8'h34);
      chk("R4 ff after low byte", ff_o, 1);
      io_write(4'h2, 8'h12);
      chk("R4 ff after high byte", ff_o, 0);
      chk("R3 base addr ch1", base_addr_o[31:16], 16'h1234);
      chk("R3 cur addr ch1", cur_addr_o[31:16], 16'h1234);
      io_read(4'h2, 8'h34, "R3 read ch1 addr low");
      io_read(4'h2, 8'h12, "R3 read ch1 addr high");
      // R3 channel 2 count register
      io_write(4'h5, 8'hCD);
      io_write(4'h5, 8'hAB);
      chk("R3 base cnt ch2", base_cnt_o[47:32], 16'hABCD);
      chk("R3 ch2 addr untouched", cur_addr_o[47:32], 16'h0000);
      io_read(4'h5, 8'hCD, "R3 read ch2 cnt low");
      io_read(4'h5, 8'hAB, "R3 read ch2 cnt high");

      // R5 pointer set/clear ignore data
      io_write(4'hD, 8'h00);
      chk("R5 set ptr", ff_o, 1);
      io_read(4'h2, 8'h12, "R5 high byte after set");
      chk("R4 ff toggled by read", ff_o, 0);
      io_write(4'hD, 8'h00);
      io_write(4'hC, 8'hFF);
      chk("R5 clear ptr", ff_o, 0);

      // R2 blocked accesses
      hlda = 1'b1;
      io_write(4'h0, 8'h55);
      hlda = 1'b0;
      chk("R2 ptr unmoved", ff_o, 0);
      chk("R2 ch0 addr unchanged", cur_addr_o[15:0], 16'h0000);
      seq_idle = 1'b0;
      io_write(4'h8, 8'h77);
      seq_idle = 1'b1;
      chk("R2 cmd unchanged", cmd_o, 0);

      // R10 command register
      io_write(4'h8, 8'hA5);
      chk("R10 cmd write", cmd_o, 8'hA5);

      // R7 masks
      io_write(4'hF, 8'hFF);
      chk("R7 clear mask", mask_o, 4'h0);
      io_write(4'h9, 8'h06);
      chk("R7 single mask set ch2", mask_o, 4'h4);
      io_write(4'h9, 8'h02);
      chk("R7 single mask clear ch2", mask_o, 4'h0);
      io_write(4'hB, 8'h09);
      chk("R7 all mask", mask_o, 4'h9);
      io_read(4'hF, 8'h09, "R7 mask readback");

      // R8 modes and readback counter
      io_write(4'hA, 8'hA9);
      io_write(4'hA, 8'h57);
      chk("R8 mode ch1", mode_o[11:6], 6'h2A);
      chk("R8 mode ch3", mode_o[23:18], 6'h15);
      io_read(4'hC, 8'h00, "R8 clear mode counter");
      io_read(4'hA, 8'h00, "R8 mode read n0");
      io_read(4'hA, 8'hA9, "R8 mode read n1");
      io_read(4'hA, 8'h02, "R8 mode read n2");
      io_read(4'hA, 8'h57, "R8 mode read n3");
      io_read(4'hA, 8'h00, "R8 mode read wrap");
      io_read(4'hA, 8'hA9, "R8 mode read n1 again");
      io_read(4'hC, 8'h00, "R8 clear mode counter again");
      io_read(4'hA, 8'h00, "R8 mode read after clear");

      // R9 status
      req_in = 4'b0101;
      pulse_tc(4'b0010);
      io_read(4'h8, 8'h52, "R9 status with tc");
      io_read(4'h8, 8'h50, "R9 status tc cleared");

      // R10 temporary register
      @(posedge clk); #1 temp_we = 1'b1; temp_data = 8'h3C;
      @(posedge clk); #1 temp_we = 1'b0;
      io_read(4'hE, 8'h3C, "R10 temp read");

      // R6 master clear
      io_write(4'hD, 8'h00);
      pulse_tc(4'b1000);
      io_write(4'hE, 8'h5A);
      chk("R6 mask set", mask_o, 4'hF);
      chk("R6 cmd cleared", cmd_o, 0);
      chk("R6 ptr cleared", ff_o, 0);
      io_read(4'h8, 8'h50, "R6 tc cleared");
      io_read(4'hE, 8'h00, "R6 temp cleared");
      io_read(4'hA, 8'h00, "R6 mode counter cleared");

      // R11 no drive outside a read
      @(negedge clk);
      chk("R11 dout_en idle", dout_en, 0);
      chk("R11 dout idle", dout, 0);
      chk("R11 queue drained", exp_q.size(), 0);

      finish_run();
   end
endmodule